// File: doc/BRIEF.md
# SD Data-Line Block Transfer Unit

This unit is the host side of the SD card data lines. It moves one block of bytes in either direction over one line (DAT0 only) or four lines (DAT3..DAT0). The byte side is a plain stream: on a write the unit pulls bytes through `wr_byte` and signals each pull with `wr_take`, and on a read it presents each assembled byte with a one-cycle `rd_vld`. The bus width and the block length in bytes are captured when a transfer starts. Everything runs on the card clock, one bit per line per cycle. The clock is never gated, so the card can always release its busy signal.

A write waits a fixed number of quiet cycles after the start request. It then sends a start bit, the data, a separate 16-bit CRC for each active line, and an end bit. After that it releases the lines and listens on DAT0 for the card's status token. Once the token ends, it follows the card's busy signal. A read waits for a start bit, which may come after any gap, then assembles the bytes and checks every active line's CRC. Both directions finish with a `done` pulse. Two sticky flags report the outcome: a CRC problem, or a missing or overlong response.

Top module: `sdx_xfer`

## Requirements
- R1: After reset all lines are undriven (`dat_oe`=0, `dat_out`=4'hF), and `done`, `rd_vld`, `wr_take`, `card_busy`, `crc_err` and `timeout` are all 0.
- R2: Once `wr_go` is sampled, the lines stay undriven for WR_GAP cycles (at least 2). Then one start-bit cycle drives 0 on every active line.
- R3: Data bit order. In 1-bit mode (`wide`=0) each byte goes out MSB first on DAT0, only DAT0 is driven, and the other lines read back 1 in `dat_out`. In 4-bit mode (`wide`=1) each byte goes out in two cycles, high nibble first, with nibble bit i on DAT i.
- R4: Each active line carries its own CRC16 over only the bits sent on that line. The polynomial is x^16+x^12+x^5+1, the register starts at zero, and the first bit is the highest-order term. The CRC goes out MSB first in 16 cycles after the data. One end-bit cycle of 1 follows, and then the lines are released.
- R5: After the release the unit samples DAT0 for up to TOK_WIN cycles, waiting for a 0 start bit. It then takes three code bits, MSB first, and one end bit. At `done`, `crc_err` is 1 unless the code was 3'b010.
- R6: If no token start bit arrives within TOK_WIN samples, the unit ends with `done` and `timeout`=1 instead of waiting forever.
- R7: `card_busy` is high from the cycle after the token end bit for as long as DAT0 is sampled low. `done` follows in the cycle after DAT0 is first sampled high.
- R8: If DAT0 is sampled low for BUSY_MAX cycles in the busy phase, the transfer ends with `timeout`=1.
- R9: A read accepts a start bit (DAT0 low) after a gap of fewer than RD_WIN high samples. It assembles bytes in the same bit order as R3 and raises `rd_vld` with the byte for one cycle, in the cycle after the byte's last bit is sampled.
- R10: The end of a read (16 CRC cycles and one end-bit cycle after the data) brings one `done` pulse, with `crc_err`=1 when the received CRC of any active line differs from the CRC of that line's data.
- R11: If no read start bit arrives within RD_WIN samples, the read ends with `done` and `timeout`=1.
- R12: `done` lasts exactly one cycle. `crc_err` and `timeout` change only together with `done`, stay set afterwards, and are cleared when the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset |
| wide | input | 1 | 1 = four data lines, 0 = DAT0 only (captured at start) |
| blk_len | input | LEN_W | Block length in bytes, at least 1 (captured at start) |
| wr_go | input | 1 | Start a block write |
| rd_go | input | 1 | Start a block read |
| wr_byte | input | 8 | Next byte to send |
| wr_take | output | 1 | `wr_byte` is captured at this clock edge |
| dat_in | input | 4 | Sampled state of DAT3..DAT0 |
| dat_out | output | 4 | Value driven on DAT3..DAT0 |
| dat_oe | output | 4 | Per-line drive enable |
| rd_byte | output | 8 | Received byte |
| rd_vld | output | 1 | `rd_byte` is valid this cycle |
| card_busy | output | 1 | Card is holding DAT0 low after a write |
| done | output | 1 | One-cycle end-of-transfer pulse |
| crc_err | output | 1 | Bad status token on write or CRC mismatch on read |
| timeout | output | 1 | Missing token, missing read start, or overlong busy |

## Verification
The assertions check on every cycle that 1-bit mode never drives DAT1..DAT3, that the line stays quiet right after a write request, that `done` is a single-cycle pulse, and that the outcome flags rise only together with `done`. They also check that busy drops once DAT0 is sampled high and that each received byte follows a completed byte slot. The actual CRC values, the nibble ordering, the status code decoding and the exact cycle at which each window expires can only be seen in the bench's scenarios. There, a behavioural model predicts every line value and byte cycle by cycle, for both widths, for good and damaged CRCs, and for missing or stuck card responses.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_WST, S_WDAT, S_WCRC, S_WEND,
    S_TOK, S_TBIT, S_TEND, S_BUSY,
    S_RST, S_RDAT, S_RCRC, S_REND, S_DONE
  } sdx_st_t;

  // One serial step of the x^16+x^12+x^5+1 remainder, message bit in at the top.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    logic [15:0] n;
    fb = c[15] ^ b;
    n  = {c[14:0], 1'b0};
    if (fb) n = n ^ 16'h1021;
    return n;
  endfunction

  localparam logic [2:0] TOK_OK = 3'b010;

endpackage

// File: rtl/sdx_crc_lane.sv
module sdx_crc_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic        shf,
  input  logic        bin,
  output logic [15:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= sdx_pkg::crc16_step(crc, bin);
    else if (shf) crc <= {crc[14:0], 1'b0};
  end

  // R4: each transfer starts its line remainder from zero
  a_r4_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 16'h0));

endmodule

// File: rtl/sdx_bit_map.sv
module sdx_bit_map (
  input  logic [7:0] b,
  input  logic [2:0] ph,
  input  logic       wide,
  output logic [3:0] bits
);

  always_comb begin
    if (wide) bits = ph[0] ? b[3:0] : b[7:4];
    else      bits = {3'b111, b[3'd7 - ph]};
  end

endmodule

// File: rtl/sdx_xfer.sv
module sdx_xfer #(
  parameter int LEN_W    = 10,
  parameter int WR_GAP   = 2,
  parameter int TOK_WIN  = 16,
  parameter int BUSY_MAX = 200,
  parameter int RD_WIN   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             wr_go,
  input  logic             rd_go,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  input  logic [3:0]       dat_in,
  output logic [3:0]       dat_out,
  output logic [3:0]       dat_oe,
  output logic [7:0]       rd_byte,
  output logic             rd_vld,
  output logic             card_busy,
  output logic             done,
  output logic             crc_err,
  output logic             timeout
);
  import sdx_pkg::*;

  localparam int LIM_A = (TOK_WIN > BUSY_MAX) ? TOK_WIN : BUSY_MAX;
  localparam int LIM_B = (LIM_A > RD_WIN) ? LIM_A : RD_WIN;
  localparam int LIM   = (LIM_B > WR_GAP + 16) ? LIM_B : WR_GAP + 16;
  localparam int CW    = $clog2(LIM + 1);
  localparam int LANES = 4;

  sdx_st_t          st;
  logic [CW-1:0]    cnt;
  logic [2:0]       ph;
  logic [LEN_W-1:0] bcnt, len_q;
  logic [7:0]       sh;
  logic [2:0]       code;
  logic             wd;

  logic [3:0]  act, tx_bits, crc_msb, lane_nz;
  logic [15:0] lane_crc [LANES];
  logic        ph_last, byte_last, ev_byte_end, ev_blk_end, ev_start, crc_bad;
  logic        lane_clr, lane_upd, lane_shf, in_wr_dat;
  logic [7:0]  rx_byte;

  assign act         = wd ? 4'hF : 4'h1;
  assign ph_last     = wd ? (ph == 3'd1) : (ph == 3'd7);
  assign byte_last   = (bcnt == len_q - 1'b1);
  assign ev_byte_end = (st == S_WDAT || st == S_RDAT) && ph_last;
  assign ev_blk_end  = ev_byte_end && byte_last;
  assign ev_start    = (st == S_IDLE) && (wr_go || rd_go);
  assign rx_byte     = wd ? {sh[3:0], dat_in} : {sh[6:0], dat_in[0]};
  assign in_wr_dat   = (st == S_WDAT);

  assign lane_clr = ev_start;
  assign lane_upd = in_wr_dat || st == S_RDAT || st == S_RCRC;
  assign lane_shf = (st == S_WCRC);

  sdx_bit_map u_map (.b(sh), .ph(ph), .wide(wd), .bits(tx_bits));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sdx_crc_lane u_lane (
      .clk(clk), .rst_n(rst_n), .clr(lane_clr), .upd(lane_upd), .shf(lane_shf),
      .bin(in_wr_dat ? tx_bits[l] : dat_in[l]), .crc(lane_crc[l]));
    assign crc_msb[l] = lane_crc[l][15];
    assign lane_nz[l] = |lane_crc[l];
  end

  assign crc_bad = |(act & lane_nz);

  always_comb begin
    dat_oe  = 4'h0;
    dat_out = 4'hF;
    unique case (st)
      S_WST:  begin dat_oe = act; dat_out = ~act;            end
      S_WDAT: begin dat_oe = act; dat_out = tx_bits | ~act;  end
      S_WCRC: begin dat_oe = act; dat_out = crc_msb | ~act;  end
      S_WEND: begin dat_oe = act; dat_out = 4'hF;            end
      default: ;
    endcase
  end

  assign wr_take   = (st == S_WST) || (in_wr_dat && ph_last && !byte_last);
  assign card_busy = (st == S_BUSY);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; bcnt <= '0; len_q <= '0;
      sh <= '0; code <= '0; wd <= 1'b0;
      rd_byte <= '0; rd_vld <= 1'b0; crc_err <= 1'b0; timeout <= 1'b0;
    end else begin
      rd_vld <= 1'b0;
      unique case (st)
        S_IDLE: if (ev_start) begin
          wd <= wide; len_q <= blk_len; cnt <= '0;
          crc_err <= 1'b0; timeout <= 1'b0;
          st <= wr_go ? S_GAP : S_RST;
        end
        S_GAP: if (cnt == CW'(WR_GAP - 1)) st <= S_WST; else cnt <= cnt + 1'b1;
        S_WST: begin sh <= wr_byte; ph <= '0; bcnt <= '0; st <= S_WDAT; end
        S_WDAT, S_RDAT: begin
          if (st == S_RDAT) sh <= rx_byte;
          if (st == S_RDAT && ph_last) begin rd_byte <= rx_byte; rd_vld <= 1'b1; end
          if (ph_last) begin
            ph <= '0;
            if (byte_last) begin
              cnt <= '0;
              st  <= (st == S_WDAT) ? S_WCRC : S_RCRC;
            end else begin
              bcnt <= bcnt + 1'b1;
              if (st == S_WDAT) sh <= wr_byte;
            end
          end else ph <= ph + 1'b1;
        end
        S_WCRC: if (cnt == CW'(15)) st <= S_WEND; else cnt <= cnt + 1'b1;
        S_WEND: begin st <= S_TOK; cnt <= '0; end
        S_TOK:
          if (!dat_in[0]) begin st <= S_TBIT; cnt <= '0; end
          else if (cnt == CW'(TOK_WIN - 1)) begin timeout <= 1'b1; st <= S_DONE; end
          else cnt <= cnt + 1'b1;
        S_TBIT: begin
          code <= {code[1:0], dat_in[0]};
          if (cnt == CW'(2)) st <= S_TEND; else cnt <= cnt + 1'b1;
        end
        S_TEND: begin st <= S_BUSY; cnt <= '0; end
        S_BUSY:
          if (dat_in[0]) begin crc_err <= (code != TOK_OK); st <= S_DONE; end
          else if (cnt == CW'(BUSY_MAX - 1)) begin
            crc_err <= (code != TOK_OK); timeout <= 1'b1; st <= S_DONE;
          end else cnt <= cnt + 1'b1;
        S_RST:
          if (!dat_in[0]) begin st <= S_RDAT; ph <= '0; bcnt <= '0; end
          else if (cnt == CW'(RD_WIN - 1)) begin timeout <= 1'b1; st <= S_DONE; end
          else cnt <= cnt + 1'b1;
        S_RCRC: if (cnt == CW'(15)) st <= S_REND; else cnt <= cnt + 1'b1;
        S_REND: begin crc_err <= crc_bad; st <= S_DONE; end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: in 1-bit mode only DAT0 is ever driven
  a_r3_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd && dat_oe != 4'h0) |-> (dat_oe == 4'h1));
  // R2: no drive in the cycle after a write request
  a_r2_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && wr_go) |=> (dat_oe == 4'h0));
  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12: outcome flags rise only with done
  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> done);
  a_r12_tmo_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
  // R7: busy ends as soon as DAT0 is seen high
  a_r7_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (card_busy && dat_in[0]) |=> (!card_busy && done));
  // R9: a received byte follows a completed read byte slot
  a_r9_vld_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(ev_byte_end && st == S_RDAT));
  // R4: the block end hands over to the CRC phase
  a_r4_crc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_blk_end && in_wr_dat) |=> (st == S_WCRC));

endmodule

// File: tb/sdx_xfer_tb.sv
module sdx_xfer_tb;
  localparam int CLK_NS   = 10;
  localparam int LEN_W    = 10;
  localparam int WR_GAP   = 2;
  localparam int TOK_WIN  = 16;
  localparam int BUSY_MAX = 200;
  localparam int RD_WIN   = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide = 1'b0, wr_go = 1'b0, rd_go = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [3:0] dat_in = 4'hF;
  logic [7:0] wr_byte, rd_byte;
  logic wr_take, rd_vld, card_busy, done, crc_err, timeout;
  logic [3:0] dat_out, dat_oe;

  logic [7:0] wq [0:64];
  int widx = 0;
  assign wr_byte = wq[widx];

  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sdx_xfer #(.LEN_W(LEN_W), .WR_GAP(WR_GAP), .TOK_WIN(TOK_WIN),
             .BUSY_MAX(BUSY_MAX), .RD_WIN(RD_WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .blk_len(blk_len),
    .wr_go(wr_go), .rd_go(rd_go), .wr_byte(wr_byte), .wr_take(wr_take),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .rd_byte(rd_byte),
    .rd_vld(rd_vld), .card_busy(card_busy), .done(done),
    .crc_err(crc_err), .timeout(timeout));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Long division of the message followed by 16 zeros by 0x11021.
  function automatic logic [15:0] ref_crc(input logic [511:0] v, input int len);
    logic [16:0] r = '0;
    for (int i = 0; i < len + 16; i++) begin
      r = {r[15:0], (i < len) ? v[i] : 1'b0};
      if (r[16]) r = r ^ 17'h11021;
    end
    return r[15:0];
  endfunction

  // Line values (lanes 3..0) in each slot of a byte: 2 slots wide, 8 narrow.
  function automatic logic [3:0] slot_bits(input logic [7:0] b, input int s, input bit w);
    logic [3:0] nib;
    if (w) begin
      nib = (s == 0) ? b[7:4] : b[3:0];
      return nib;
    end
    return {3'b111, b[7 - s]};
  endfunction

  task automatic build(input bit w, input int n, input int seed,
                       output logic [3:0] sl[$], output logic [15:0] crcs[4]);
    logic [511:0] lb [4];
    int ln = 0;
    int spb = w ? 2 : 8;
    sl = {};
    for (int l = 0; l < 4; l++) lb[l] = '0;
    for (int i = 0; i < n; i++) begin
      wq[i] = 8'((i * 53 + seed * 17 + 9) & 255);
      for (int s = 0; s < spb; s++) begin
        logic [3:0] bits = slot_bits(wq[i], s, w);
        sl.push_back(bits);
        for (int l = 0; l < 4; l++) lb[l][ln] = bits[l];
        ln++;
      end
    end
    for (int l = 0; l < 4; l++) crcs[l] = ref_crc(lb[l], ln);
  endtask

  task automatic do_wr(input bit w, input int n, input int seed, input bit send_tok,
                       input int tokgap, input logic [2:0] code, input int busy);
    logic [3:0] sl[$];
    logic [15:0] crcs[4];
    logic [7:0] exq[$];
    logic [3:0] act = w ? 4'hF : 4'h1;
    bit take_prev = 0;
    bit exp_tmo;
    build(w, n, seed, sl, crcs);
    for (int i = 0; i < WR_GAP; i++) exq.push_back({4'h0, 4'hF});
    exq.push_back({act, ~act});
    foreach (sl[i]) exq.push_back({act, sl[i] | ~act});
    for (int k = 15; k >= 0; k--)
      exq.push_back({act, {crcs[3][k], crcs[2][k], crcs[1][k], crcs[0][k]} | ~act});
    exq.push_back({act, 4'hF});
    widx = 0;
    wide = w; blk_len = LEN_W'(n); wr_go = 1'b1; dat_in = 4'hF;
    @(negedge clk);
    wr_go = 1'b0;
    chk("R12 flags cleared at start", {crc_err, timeout}, 2'b00);
    foreach (exq[i]) begin
      if (take_prev) widx++;
      take_prev = wr_take;
      chk("R2 R3 R4 write line slot", {dat_oe, dat_out}, exq[i]);
      @(negedge clk);
    end
    chk("R4 lines released", dat_oe, 4'h0);
    exp_tmo = 0;
    if (!send_tok) begin
      repeat (TOK_WIN) begin chk("R6 waiting", done, 1'b0); @(negedge clk); end
      exp_tmo = 1;
    end else begin
      repeat (tokgap) begin chk("R5 waiting", done, 1'b0); @(negedge clk); end
      dat_in = 4'hE; @(negedge clk);
      for (int k = 2; k >= 0; k--) begin dat_in = {3'b111, code[k]}; @(negedge clk); end
      dat_in = 4'hF;
      chk("R7 not busy during end bit", card_busy, 1'b0);
      @(negedge clk);
      if (busy >= BUSY_MAX) begin
        repeat (BUSY_MAX) begin
          chk("R8 busy phase", card_busy, 1'b1); dat_in = 4'hE; @(negedge clk);
        end
        exp_tmo = 1;
      end else begin
        repeat (busy) begin
          chk("R7 busy phase", card_busy, 1'b1); dat_in = 4'hE; @(negedge clk);
        end
        chk("R7 busy until release", card_busy, 1'b1);
        dat_in = 4'hF; @(negedge clk);
      end
    end
    dat_in = 4'hF;
    chk("R7 R6 R8 done pulse", done, 1'b1);
    chk("R6 R8 timeout flag", timeout, exp_tmo);
    chk("R5 token code flag", crc_err, send_tok && code != 3'b010);
    @(negedge clk);
    chk("R12 done one cycle", done, 1'b0);
    chk("R12 flags held", {crc_err, timeout}, {send_tok && code != 3'b010, exp_tmo});
  endtask

  task automatic do_rd(input bit w, input int n, input int seed, input int gap,
                       input bit corrupt, input bit nostart);
    logic [3:0] sl[$];
    logic [15:0] crcs[4];
    logic [3:0] din[$];
    logic [8:0] ex[$];
    int spb = w ? 2 : 8;
    wide = w; blk_len = LEN_W'(n); rd_go = 1'b1; dat_in = 4'hF;
    @(negedge clk);
    rd_go = 1'b0;
    if (nostart) begin
      repeat (RD_WIN) begin chk("R11 waiting", done, 1'b0); @(negedge clk); end
      chk("R11 done", done, 1'b1);
      chk("R11 timeout", timeout, 1'b1);
      @(negedge clk);
      return;
    end
    build(w, n, seed, sl, crcs);
    for (int i = 0; i < gap; i++) begin din.push_back(4'hF); ex.push_back('0); end
    din.push_back(w ? 4'h0 : 4'hE); ex.push_back('0);
    foreach (sl[i]) begin
      din.push_back(sl[i]);
      ex.push_back((i % spb == spb - 1) ? {1'b1, wq[i / spb]} : 9'h0);
    end
    for (int k = 15; k >= 0; k--) begin
      logic [3:0] c = {crcs[3][k], crcs[2][k], crcs[1][k], crcs[0][k]};
      if (corrupt && k == 5) c[0] = ~c[0];
      din.push_back(w ? c : {3'b111, c[0]}); ex.push_back('0);
    end
    din.push_back(4'hF); ex.push_back('0);
    foreach (din[i]) begin
      dat_in = din[i];
      @(negedge clk);
      chk("R9 byte valid", rd_vld, ex[i][8]);
      if (ex[i][8]) chk("R9 byte value", rd_byte, ex[i][7:0]);
    end
    dat_in = 4'hF;
    chk("R10 done", done, 1'b1);
    chk("R10 crc flag", crc_err, corrupt);
    chk("R11 no timeout", timeout, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {dat_oe, dat_out}, 8'h0F);
    chk("R1 reset status", {done, rd_vld, wr_take, card_busy, crc_err, timeout}, 6'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_wr(1'b1, 4, 1, 1'b1, 3, 3'b010, 5);
    do_wr(1'b0, 2, 2, 1'b1, 0, 3'b010, 0);
    do_wr(1'b1, 1, 3, 1'b1, 1, 3'b101, 2);
    do_wr(1'b1, 3, 4, 1'b0, 0, 3'b010, 0);
    do_wr(1'b0, 1, 5, 1'b1, 2, 3'b010, BUSY_MAX);
    do_rd(1'b1, 4, 6, 7, 1'b0, 1'b0);
    do_rd(1'b0, 3, 7, 0, 1'b0, 1'b0);
    do_rd(1'b1, 2, 8, 2, 1'b1, 1'b0);
    do_rd(1'b0, 1, 9, 4, 1'b1, 1'b0);
    do_rd(1'b1, 1, 0, 0, 1'b0, 1'b1);
    do_wr(1'b1, 2, 10, 1'b1, 0, 3'b010, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule